// File: doc/BRIEF.md
# Counted Serial Shift Engine with Two-Wire Support

The engine moves a byte in or out over a single shared data line, one bit per serial clock period, for a number of bits set by a count register. Writing a non-zero count starts the transfer. Each bit lowers the serial clock, updates the data output while the clock is low, then raises the clock and samples the data line into the bottom of the shift register. When the count reaches zero, the done flag rises. Software sequences a two-wire transaction (start, address, acknowledge, data, stop) by writing a short count for each step and reacting to the flag.

The data line is open-drain. The engine can only pull it low, and only while its output enable is set. A bypass control ties the line straight to the shift register's top bit, with no clock edge in between. Loading 0x00 or 0xFF with SCL high then makes a start or a stop condition. In hold-until-acknowledge mode, a raised flag keeps SCL low until software clears the flag, which stretches the bus clock between steps.

Processor access is a simple strobed write port with a 2-bit register select. The shift register contents are always visible on a read-back port.

Top module: `ser_shift_engine`

## Requirements
- R1: Writing count N (select 1, low 5 bits) with N non-zero produces exactly N rising edges on `scl_out`. Writing 0 produces none.
- R2: `flag_out` rises at the Nth rising edge. When hold mode is off, a count write clears it.
- R3: In hold mode (select 3, bit 0 = 1), a raised flag drives `scl_out` low and keeps it low. Writing select 3 with bit 1 = 1 clears the flag, and a pending transfer then continues.
- R4: With bypass (control bit 2) and output enable set, `sda_pull_low` equals the inverse of shift register bit 7 one cycle after a data write (select 2), while `scl_out` stays high.
- R5: With output enable (control bit 1) clear, `sda_pull_low` stays 0 in every mode.
- R6: `scl_out` idles high. During a transfer the driven data changes only while `scl_out` is low, and the line is sampled on the rising edge.
- R7: Each SCL half-period lasts 2^D source pulses, where D is control bits 6:4. The source is the system clock, or `ext_tick` pulses when control bit 3 is set. With D = 3 on the system clock, the SCL period is 16 cycles.
- R8: Bits leave MSB first, and each sampled bit enters at bit 0. After 8 bits, `rd_data` holds the byte seen on the line.
- R9: While control bit 0 (soft reset) is set, a count write starts nothing, `scl_out` stays high and the flag stays low. Reset sets this bit.
- R10: A count write leaves the hold-mode setting unchanged.
- R11: After reset, `scl_out` is 1, `flag_out` is 0, `sda_pull_low` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 count, 2 data, 3 mode/flag clear |
| wr_data | input | 8 | Write data |
| ext_tick | input | 1 | External clock-source pulse |
| sda_in | input | 1 | Level of the shared data line |
| sda_pull_low | output | 1 | 1 pulls the data line low; 0 releases it |
| scl_out | output | 1 | Serial clock |
| flag_out | output | 1 | Transfer-done flag |
| rd_data | output | 8 | Shift register contents |

## Verification
A wrong bit counter shows up as a rising-edge count on `scl_out` that differs from the value written, and as a flag that comes early or late. Both are visible within one transfer. A shift in the wrong direction, or a sample taken on the wrong edge, corrupts `rd_data` and the captured line byte at the end of a single 8-bit transfer. Hold-mode faults appear as SCL rising while the flag is still set, or staying low after the flag is cleared, and show within a few SCL half-periods. A latch that updates while SCL is high shows as a data-line change during a high phase, which is itself an illegal start or stop on the bus.

// File: rtl/sse_pkg.sv
package sse_pkg;
  localparam int DIV_W = 3;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_DATA  = 2'd2,
    SEL_MODE  = 2'd3
  } wr_sel_e;

  typedef struct packed {
    logic [DIV_W-1:0] div_exp;
    logic             src_ext;
    logic             bypass;
    logic             oe;
    logic             srst;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{div_exp: '0, src_ext: 1'b0, bypass: 1'b0, oe: 1'b0, srst: 1'b1};
endpackage

// File: rtl/sse_clkdiv.sv
module sse_clkdiv #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             src_ext,
  input  logic             ext_tick,
  input  logic [EXP_W-1:0] div_exp,
  output logic             tick
);
  localparam int CW = (1 << EXP_W) - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] mask;
  logic          pulse;

  assign pulse = src_ext ? ext_tick : 1'b1;
  assign mask  = ~({CW{1'b1}} << div_exp);
  assign tick  = run && pulse && ((cnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (pulse)  cnt_q <= cnt_q + 1'b1;
  end

  // R7: with a divided internal source, half-period ticks never come back to back
  p_tick_gap_r7: assert property (@(posedge clk) disable iff (rst || !run)
    (tick && !src_ext && div_exp != '0) |=> (!tick || div_exp != $past(div_exp) || $past(src_ext) != src_ext));
endmodule

// File: rtl/sse_shifter.sv
module sse_shifter #(
  parameter int DW        = 8,
  parameter int CNT_W     = 5,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srst,
  input  logic             tick,
  input  logic             manual,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             data_wr,
  input  logic [DW-1:0]    data_val,
  input  logic             flag_clr,
  input  logic             sda_in,
  output logic [DW-1:0]    sr_q,
  output logic             scl_q,
  output logic             lat_q,
  output logic             flag_q,
  output logic             busy_q,
  output logic             out_bit
);
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]    sr_next;
  logic             stretch;

  generate
    if (MSB_FIRST) begin : g_msb
      assign sr_next = {sr_q[DW-2:0], sda_in};
      assign out_bit = sr_q[DW-1];
    end else begin : g_lsb
      assign sr_next = {sda_in, sr_q[DW-1:1]};
      assign out_bit = sr_q[0];
    end
  endgenerate

  assign stretch = flag_q & manual;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      lat_q  <= 1'b1;
      scl_q  <= 1'b1;
      flag_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      // output latch is transparent only while the serial clock is low
      if (!scl_q) lat_q <= out_bit;
      if (srst) begin
        scl_q  <= 1'b1;
        flag_q <= 1'b0;
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        if (flag_clr) flag_q <= 1'b0;
        if (tick) begin
          if (busy_q) begin
            if (scl_q) begin
              scl_q <= 1'b0;
            end else if (!stretch) begin
              scl_q <= 1'b1;
              sr_q  <= sr_next;
              cnt_q <= cnt_q - 1'b1;
              if (cnt_q == CNT_W'(1)) begin
                busy_q <= 1'b0;
                flag_q <= 1'b1;
              end
            end
          end else begin
            scl_q <= !stretch;
          end
        end
        if (cnt_wr) begin
          cnt_q  <= cnt_val;
          busy_q <= (cnt_val != '0);
          if (!manual) flag_q <= 1'b0;
        end
      end
      if (data_wr) sr_q <= data_val;
    end
  end

  // R1: a non-zero count write arms the engine
  p_start_r1: assert property (@(posedge clk) disable iff (rst || srst)
    (cnt_wr && cnt_val != '0) |=> busy_q);

  // R2: the end of a counted transfer leaves the flag raised
  p_done_flag_r2: assert property (@(posedge clk) disable iff (rst || srst)
    ($fell(busy_q) && !$past(cnt_wr)) |-> flag_q);

  // R3: in hold mode a pending flag keeps the serial clock low
  p_stretch_low_r3: assert property (@(posedge clk) disable iff (rst || srst)
    (flag_q && manual && !scl_q) |=> !scl_q);

  // R6: driven data does not move during a high clock phase
  p_latch_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (scl_q && $past(scl_q)) |-> $stable(lat_q));
endmodule

// File: rtl/sse_sda_out.sv
module sse_sda_out (
  input  logic oe,
  input  logic bypass,
  input  logic msb,
  input  logic lat,
  output logic pull_low
);
  logic level;

  assign level    = bypass ? msb : lat;
  assign pull_low = oe & ~level;

  // R5: the line is never pulled without the output enable
  always_comb begin
    p_no_drive_r5: assert (!pull_low || oe);
  end
endmodule

// File: rtl/ser_shift_engine.sv
module ser_shift_engine
  import sse_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          ext_tick,
  input  logic          sda_in,
  output logic          sda_pull_low,
  output logic          scl_out,
  output logic          flag_out,
  output logic [DW-1:0] rd_data
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t ctrl_q;
  logic  manual_q;
  logic  cnt_wr, data_wr, flag_clr, tick;
  logic  lat, busy, out_bit;

  assign cnt_wr   = wr_en && (wr_sel == SEL_COUNT);
  assign data_wr  = wr_en && (wr_sel == SEL_DATA);
  assign flag_clr = wr_en && (wr_sel == SEL_MODE) && wr_data[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= CTRL_RST;
      manual_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel_e'(wr_sel))
        SEL_CTRL: ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
        SEL_MODE: manual_q <= wr_data[0];
        default:  ;
      endcase
    end
  end

  sse_clkdiv #(.EXP_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .run     (!ctrl_q.srst),
    .src_ext (ctrl_q.src_ext),
    .ext_tick(ext_tick),
    .div_exp (ctrl_q.div_exp),
    .tick    (tick)
  );

  sse_shifter #(.DW(DW), .CNT_W(CNT_W), .MSB_FIRST(1'b1)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .srst    (ctrl_q.srst),
    .tick    (tick),
    .manual  (manual_q),
    .cnt_wr  (cnt_wr),
    .cnt_val (wr_data[CNT_W-1:0]),
    .data_wr (data_wr),
    .data_val(wr_data),
    .flag_clr(flag_clr),
    .sda_in  (sda_in),
    .sr_q    (rd_data),
    .scl_q   (scl_out),
    .lat_q   (lat),
    .flag_q  (flag_out),
    .busy_q  (busy),
    .out_bit (out_bit)
  );

  sse_sda_out u_sda (
    .oe      (ctrl_q.oe),
    .bypass  (ctrl_q.bypass),
    .msb     (out_bit),
    .lat     (lat),
    .pull_low(sda_pull_low)
  );

  // R9: soft reset keeps the engine idle with the clock high
  p_srst_idle_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_q.srst) && ctrl_q.srst) |-> (scl_out && !busy && !flag_out));

  // R10: count writes never alter the hold-mode setting
  p_mode_kept_r10: assert property (@(posedge clk) disable iff (rst)
    $past(cnt_wr) |-> (manual_q == $past(manual_q)));
endmodule

// File: tb/ser_shift_engine_bench.sv
module ser_shift_engine_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       ext_tick = 1'b0;
  logic       slave_low = 1'b0;
  logic       sda_pull_low, scl_out, flag_out;
  logic [7:0] rd_data;
  logic       sda_line;

  int checks = 0, fails = 0;
  int cyc = 0, rises = 0, falls = 0;
  int fall_t0 = 0, fall_t1 = 0;
  logic [7:0] cap = 8'd0;
  logic       slave_en = 1'b0;
  logic [7:0] slave_byte = 8'd0;
  int         slave_idx = 0;
  logic       mon_en = 1'b0, mon_oe0 = 1'b0;
  int         viol = 0, pl_seen = 0;
  logic       prev_scl = 1'b1, prev_pl = 1'b0;
  logic       ext_run = 1'b0;
  bit         done = 1'b0;

  assign sda_line = ~(sda_pull_low | slave_low);

  always #4 clk = ~clk;

  ser_shift_engine u_ser_shift_engine (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ext_tick(ext_tick), .sda_in(sda_line), .sda_pull_low(sda_pull_low),
    .scl_out(scl_out), .flag_out(flag_out), .rd_data(rd_data)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge scl_out) begin
    rises = rises + 1;
    cap = {cap[6:0], sda_line};
  end

  always @(negedge scl_out) begin
    if (falls == 0) fall_t0 = cyc;
    if (falls == 1) fall_t1 = cyc;
    falls = falls + 1;
    if (slave_en && slave_idx < 8) begin
      slave_low = ~slave_byte[7 - slave_idx];
      slave_idx = slave_idx + 1;
    end
  end

  always @(negedge clk) begin
    if (mon_en && scl_out && prev_scl && (sda_pull_low != prev_pl)) viol = viol + 1;
    if (mon_oe0 && sda_pull_low) pl_seen = pl_seen + 1;
    prev_scl = scl_out;
    prev_pl  = sda_pull_low;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_flag(input int maxc, input string tag);
    int n = 0;
    while (!flag_out && n < maxc) begin
      @(negedge clk);
      n++;
    end
    check(flag_out == 1'b1, tag, flag_out, 1);
  endtask

  task automatic clear_stamps();
    rises = 0; falls = 0; cap = 8'd0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(scl_out == 1'b1, "R11 scl after reset", scl_out, 1);
    check(flag_out == 1'b0, "R11 flag after reset", flag_out, 0);
    check(sda_pull_low == 1'b0, "R11 sda after reset", sda_pull_low, 0);
    check(rd_data == 8'h00, "R11 data after reset", rd_data, 0);
  endtask

  task automatic t_srst();
    clear_stamps();
    wr(2'd1, 8'd4);
    repeat (100) @(negedge clk);
    check(rises == 0, "R9 no clocks in soft reset", rises, 0);
    check(scl_out == 1'b1, "R9 scl high in soft reset", scl_out, 1);
    check(flag_out == 1'b0, "R9 flag low in soft reset", flag_out, 0);
  endtask

  task automatic t_tx();
    wr(2'd0, 8'h32);
    wr(2'd2, 8'hA5);
    clear_stamps();
    viol = 0; mon_en = 1'b1;
    wr(2'd1, 8'd8);
    wait_flag(400, "R2 flag after 8 bits");
    repeat (3) @(negedge clk);
    mon_en = 1'b0;
    check(rises == 8, "R1 rising edges for count 8", rises, 8);
    check(cap == 8'hA5, "R8 MSB-first line byte", cap, 8'hA5);
    check(fall_t1 - fall_t0 == 16, "R7 SCL period div 8", fall_t1 - fall_t0, 16);
    check(viol == 0, "R6 data steady while SCL high", viol, 0);
    check(scl_out == 1'b1, "R6 SCL idles high after transfer", scl_out, 1);
  endtask

  task automatic t_zero();
    clear_stamps();
    wr(2'd1, 8'd0);
    repeat (100) @(negedge clk);
    check(rises == 0, "R1 count 0 starts nothing", rises, 0);
    check(flag_out == 1'b0, "R2 count write clears flag", flag_out, 0);
  endtask

  task automatic t_rx();
    wr(2'd0, 8'h30);
    wr(2'd2, 8'h00);
    clear_stamps();
    slave_byte = 8'h3C; slave_idx = 0; slave_en = 1'b1;
    pl_seen = 0; mon_oe0 = 1'b1;
    wr(2'd1, 8'd8);
    wait_flag(400, "R2 flag after receive");
    @(negedge clk);
    mon_oe0 = 1'b0; slave_en = 1'b0; slave_low = 1'b0;
    check(rd_data == 8'h3C, "R8 received byte", rd_data, 8'h3C);
    check(cap == 8'h3C, "R6 line sampled on rising edge", cap, 8'h3C);
    check(pl_seen == 0, "R5 no pull with output enable clear", pl_seen, 0);
  endtask

  task automatic t_ext();
    wr(2'd0, 8'h0A);
    clear_stamps();
    ext_run = 1'b1;
    fork
      begin
        while (ext_run) begin
          repeat (4) @(negedge clk);
          ext_tick = 1'b1;
          @(negedge clk);
          ext_tick = 1'b0;
        end
      end
    join_none
    wr(2'd1, 8'd2);
    wait_flag(200, "R2 flag with external source");
    ext_run = 1'b0;
    repeat (8) @(negedge clk);
    check(rises == 2, "R1 rising edges for count 2", rises, 2);
    check(fall_t1 - fall_t0 == 10, "R7 external source period", fall_t1 - fall_t0, 10);
  endtask

  task automatic t_bypass();
    wr(2'd0, 8'h36);
    clear_stamps();
    wr(2'd2, 8'h00);
    check(sda_pull_low == 1'b1, "R4 start level from 0x00", sda_pull_low, 1);
    check(scl_out == 1'b1, "R4 SCL high during start", scl_out, 1);
    wr(2'd2, 8'hFF);
    check(sda_pull_low == 1'b0, "R4 stop level from 0xFF", sda_pull_low, 0);
    check(rises == 0, "R4 no clock edges in bypass", rises, 0);
    wr(2'd0, 8'h34);
    wr(2'd2, 8'h00);
    check(sda_pull_low == 1'b0, "R5 bypass without output enable", sda_pull_low, 0);
  endtask

  task automatic t_manual();
    wr(2'd0, 8'h32);
    wr(2'd3, 8'h03);
    wr(2'd2, 8'h80);
    clear_stamps();
    wr(2'd1, 8'd3);
    wait_flag(200, "R2 flag in hold mode");
    repeat (40) @(negedge clk);
    check(scl_out == 1'b0, "R3 SCL held low", scl_out, 0);
    check(rises == 3, "R1 rising edges for count 3", rises, 3);
    wr(2'd1, 8'd2);
    repeat (40) @(negedge clk);
    check(flag_out == 1'b1, "R10 hold mode kept over count write", flag_out, 1);
    check(scl_out == 1'b0, "R3 SCL still held with pending count", scl_out, 0);
    check(rises == 3, "R3 no edges while held", rises, 3);
    wr(2'd3, 8'h03);
    wait_flag(200, "R3 transfer resumes after clear");
    check(rises == 5, "R3 pending bits clocked after clear", rises, 5);
    repeat (40) @(negedge clk);
    check(scl_out == 1'b0, "R3 held again after second flag", scl_out, 0);
    wr(2'd3, 8'h02);
    repeat (40) @(negedge clk);
    check(scl_out == 1'b1, "R3 SCL released after clear", scl_out, 1);
    check(flag_out == 1'b0, "R3 flag cleared", flag_out, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_srst();
    t_tx();
    t_zero();
    t_rx();
    t_ext();
    t_bypass();
    t_manual();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule